// File: doc/BRIEF.md
# Program Sequencer with Return Stack

This block owns the program counter of a small fixed-width microcontroller. It presents a 13-bit fetch address into an 8K-word program store whose words are 14 bits wide. Each cycle it chooses the next address from decoded control requests: a plain step, a conditional branch qualified by a bit-test result, an unconditional jump, a subroutine call, or a return. A step and a branch that is not taken both move to the following word. A taken branch, a jump and a call load the target address supplied with the request. A return loads the address saved by the matching call.

Return addresses live in an 8-entry circular hardware stack, so subroutines nest eight levels deep. When a ninth call is made without a return, the oldest saved address is overwritten. When a return is made with nothing saved, the entry under the wrapped pointer is used. Each of these events sets a sticky flag that only reset clears. The instruction store, the decoder, the ALU and the data registers sit outside this block.

Top module: `prog_sequencer`

## Requirements
- R1: While rst_n is low at a rising clock edge, fetch_addr becomes 0x0000 and both ovf_flag and unf_flag become 0. After reset the stack is empty and every entry holds 0x0000.
- R2: When step_en is the only request, fetch_addr increases by one at the next edge. When no request is asserted, fetch_addr holds its value.
- R3: Incrementing from 0x1FFF gives 0x0000.
- R4: A jump (jmp_req) loads tgt_addr into fetch_addr at the next edge.
- R5: A branch (br_req) with br_cond=1 loads tgt_addr. A branch with br_cond=0 advances fetch_addr by one.
- R6: A call (call_req) loads tgt_addr and saves fetch_addr+1 on the stack. A return (ret_req) loads the most recently saved address that has not yet been returned to, so eight nested calls unwind last-in first-out.
- R7: A call made while eight addresses are already saved overwrites the oldest one and sets ovf_flag. The flag then stays 1 until reset. The next eight returns give the eight newest addresses, newest first.
- R8: A return made with no saved address sets unf_flag, which stays 1 until reset. It still moves the pointer back one place and loads the entry found there, so right after reset that entry is 0x0000.
- R9: When several requests are asserted together, the one that wins is chosen in this order, highest first: return, call, jump or taken branch, then step or not-taken branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Advance to the next sequential word |
| br_req | input | 1 | Conditional branch request |
| br_cond | input | 1 | Bit-test result that qualifies br_req |
| jmp_req | input | 1 | Unconditional jump request |
| call_req | input | 1 | Subroutine call request |
| ret_req | input | 1 | Subroutine return request |
| tgt_addr | input | 13 | Target for a branch, jump or call |
| fetch_addr | output | 13 | Current program counter, used as the fetch address |
| ovf_flag | output | 1 | Sticky flag: a saved return address was overwritten |
| unf_flag | output | 1 | Sticky flag: a return was made on an empty stack |

## Verification
A stack pointer that is off by one is not visible when the call is made. It shows up only at the following return, as a wrong fetch_addr one cycle after ret_req. For that reason the stimulus unwinds a full nine-deep call chain and checks every return address. A miscounted fill level also appears late: the overflow or underflow flag sets one call or return too early or too late. The bench tracks both flags at the exact cycle where each should change. A wrong priority or a wrong next-address choice shows at fetch_addr on the very next edge, so those cases are checked one cycle after they are applied.

// File: rtl/seq_pkg.sv
// Package: shared types for the program sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package seq_pkg;
    // Source chosen for the next program counter value
    typedef enum logic [2:0] {
        NXT_HOLD = 3'd0,
        NXT_INC  = 3'd1,
        NXT_TGT  = 3'd2,
        NXT_CALL = 3'd3,
        NXT_RET  = 3'd4
    } nxt_sel_e;
endpackage

// File: rtl/seq_next_sel.sv
// Module: seq_next_sel
// Priority decoder. It turns the decoded control requests into a single
// next-address choice. Order, highest first: return, call, jump or taken
// branch, step or not-taken branch, hold.
// Assumes the requests are already synchronous to the sequencer clock.
module seq_next_sel
    import seq_pkg::*;
(
    input  logic     step_en,
    input  logic     br_req,
    input  logic     br_cond,
    input  logic     jmp_req,
    input  logic     call_req,
    input  logic     ret_req,
    output nxt_sel_e sel
);
    // Pick the winning request by fixed priority
    always_comb begin
        if (ret_req)                        sel = NXT_RET;
        else if (call_req)                  sel = NXT_CALL;
        else if (jmp_req || (br_req && br_cond)) sel = NXT_TGT;
        else if (step_en || br_req)         sel = NXT_INC;
        else                                sel = NXT_HOLD;
    end
endmodule

// File: rtl/seq_ret_stack.sv
// Module: seq_ret_stack
// Circular return-address stack. A push writes at the pointer and moves it
// up; a pop moves it down and the entry there becomes the top. The fill
// level saturates at DEPTH and at zero. A push at full sets a sticky
// overflow flag; a pop at empty sets a sticky underflow flag.
// Assumes DEPTH is a power of two and that push and pop are never both high.
module seq_ret_stack #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] top_data,
    output logic              ovf_flag,
    output logic              unf_flag
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DATA_W-1:0] entry_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [PTR_W-1:0]  top_ptr;
    logic [CNT_W-1:0]  level_q;

    // Index of the newest entry (one below the write pointer)
    assign top_ptr  = wr_ptr_q - 1'b1;
    assign top_data = entry_q[top_ptr];

    // Storage entries: clear on reset, write on push
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry_q[g] <= '0;
            else if (push && (wr_ptr_q == PTR_W'(g)))
                entry_q[g] <= push_data;
        end
    end

    // Pointer, fill level and sticky error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            level_q  <= '0;
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
        end else if (push) begin
            wr_ptr_q <= wr_ptr_q + 1'b1;
            if (level_q == FULL_CNT) ovf_flag <= 1'b1;
            else                     level_q  <= level_q + 1'b1;
        end else if (pop) begin
            wr_ptr_q <= top_ptr;
            if (level_q == '0) unf_flag <= 1'b1;
            else               level_q  <= level_q - 1'b1;
        end
    end
endmodule

// File: rtl/prog_sequencer.sv
// Module: prog_sequencer
// Program counter and control-flow unit. It holds the fetch address and
// picks the next one from step, branch, jump, call and return requests.
// Calls save PC+1 on an internal return stack. The counter wraps at the
// top of the address space.
// Assumes tgt_addr is valid whenever a branch, jump or call is requested.
module prog_sequencer #(
    parameter int ADDR_W      = 13,
    parameter int STACK_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              br_req,
    input  logic              br_cond,
    input  logic              jmp_req,
    input  logic              call_req,
    input  logic              ret_req,
    input  logic [ADDR_W-1:0] tgt_addr,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              ovf_flag,
    output logic              unf_flag
);
    import seq_pkg::*;

    nxt_sel_e          sel;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] pc_nxt;
    logic [ADDR_W-1:0] stack_top;

    seq_next_sel u_sel (
        .step_en  (step_en),
        .br_req   (br_req),
        .br_cond  (br_cond),
        .jmp_req  (jmp_req),
        .call_req (call_req),
        .ret_req  (ret_req),
        .sel      (sel)
    );

    seq_ret_stack #(
        .DEPTH  (STACK_DEPTH),
        .DATA_W (ADDR_W)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (sel == NXT_CALL),
        .pop       (sel == NXT_RET),
        .push_data (pc_inc),
        .top_data  (stack_top),
        .ovf_flag  (ovf_flag),
        .unf_flag  (unf_flag)
    );

    // Sequential successor, wrapping at the top of the address space
    assign pc_inc = pc_q + 1'b1;

    // Next-address multiplexer driven by the priority choice
    always_comb begin
        case (sel)
            NXT_INC:           pc_nxt = pc_inc;
            NXT_TGT, NXT_CALL: pc_nxt = tgt_addr;
            NXT_RET:           pc_nxt = stack_top;
            default:           pc_nxt = pc_q;
        endcase
    end

    // Program counter register
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_nxt;
    end

    assign fetch_addr = pc_q;
endmodule

// File: rtl/prog_sequencer_chk.sv
// Module: prog_sequencer_chk
// Property checker bound to prog_sequencer. It watches only the ports.
// Assumes the synchronous active-low reset of the checked block.
module prog_sequencer_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_en,
    input logic              br_req,
    input logic              br_cond,
    input logic              jmp_req,
    input logic              call_req,
    input logic              ret_req,
    input logic [ADDR_W-1:0] tgt_addr,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              ovf_flag,
    input logic              unf_flag
);
    AST_RESET_ZERO: assert property (@(posedge clk) $rose(rst_n) |-> (fetch_addr == '0 && !ovf_flag && !unf_flag)); // R1
    AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !br_req && !jmp_req && !call_req && !ret_req) |=> fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !br_req && !jmp_req && !call_req && !ret_req) |=> $stable(fetch_addr)); // R2
    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_req && !call_req && !ret_req) |=> fetch_addr == $past(tgt_addr)); // R4
    AST_BR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (br_req && br_cond && !call_req && !ret_req) |=> fetch_addr == $past(tgt_addr)); // R5
    AST_BR_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (br_req && !br_cond && !jmp_req && !call_req && !ret_req) |=> fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1)); // R5
    AST_CALL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !ret_req) |=> fetch_addr == $past(tgt_addr)); // R6
    AST_CALL_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !ret_req) ##1 ret_req |=> fetch_addr == ADDR_W'($past(fetch_addr, 2) + 1'b1)); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ovf_flag |=> ovf_flag); // R7
    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) unf_flag |=> unf_flag); // R8
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovf_flag) |-> $past(call_req && !ret_req)); // R7
    AST_UNF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(unf_flag) |-> $past(ret_req)); // R8
    AST_RET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (ret_req && call_req) |=> !$rose(ovf_flag)); // R9
endmodule

bind prog_sequencer prog_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .br_req     (br_req),
    .br_cond    (br_cond),
    .jmp_req    (jmp_req),
    .call_req   (call_req),
    .ret_req    (ret_req),
    .tgt_addr   (tgt_addr),
    .fetch_addr (fetch_addr),
    .ovf_flag   (ovf_flag),
    .unf_flag   (unf_flag)
);

// File: tb/prog_sequencer_test.sv
// Bench for prog_sequencer: a vector table followed by directed corner tests.
// Inputs change just after a falling edge; outputs are sampled at the next
// falling edge, one rising edge later.
module prog_sequencer_test;
    localparam int AW = 13;
    localparam int NV = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step_en = 1'b0, br_req = 1'b0, br_cond = 1'b0;
    logic          jmp_req = 1'b0, call_req = 1'b0, ret_req = 1'b0;
    logic [AW-1:0] tgt_addr = '0;
    logic [AW-1:0] fetch_addr;
    logic          ovf_flag, unf_flag;

    int n_chk = 0;
    int n_bad = 0;

    // Vector: {ret,call,jmp,br,cond,step}, target, expected fetch address
    localparam logic [31:0] VEC [NV] = '{
        {6'b000001, 13'h0000, 13'h0001},  // R2 step
        {6'b000001, 13'h0000, 13'h0002},  // R2 step
        {6'b000000, 13'h0123, 13'h0002},  // R2 idle hold
        {6'b001000, 13'h0100, 13'h0100},  // R4 jump
        {6'b000110, 13'h0200, 13'h0200},  // R5 taken
        {6'b000100, 13'h0300, 13'h0201},  // R5 not taken
        {6'b010000, 13'h0400, 13'h0400},  // R6 call, saves 0x202
        {6'b000001, 13'h0000, 13'h0401},  // R2 step
        {6'b010000, 13'h0800, 13'h0800},  // R6 nested call, saves 0x402
        {6'b100000, 13'h0000, 13'h0402},  // R6 return inner
        {6'b100000, 13'h0000, 13'h0202},  // R6 return outer
        {6'b001001, 13'h0050, 13'h0050},  // R9 jump over step
        {6'b011000, 13'h0060, 13'h0060},  // R9 call over jump, saves 0x51
        {6'b110000, 13'h0070, 13'h0051},  // R9 return over call
        {6'b001000, 13'h1FFE, 13'h1FFE},  // R4 jump near top
        {6'b000001, 13'h0000, 13'h1FFF},  // R2 step
        {6'b000001, 13'h0000, 13'h0000}   // R3 wrap
    };

    prog_sequencer uut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .br_req(br_req),
        .br_cond(br_cond), .jmp_req(jmp_req), .call_req(call_req),
        .ret_req(ret_req), .tgt_addr(tgt_addr), .fetch_addr(fetch_addr),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    // 50 MHz clock
    always #10 clk = ~clk;

    // Compare one value and log a miscompare
    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // Drive one request cycle and wait for its result
    task automatic apply(input logic [5:0] ctl, input logic [AW-1:0] tgt);
        {ret_req, call_req, jmp_req, br_req, br_cond, step_en} = ctl;
        tgt_addr = tgt;
        @(negedge clk);
        {ret_req, call_req, jmp_req, br_req, br_cond, step_en} = '0;
    endtask

    // Hold reset for two edges, then release
    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        check("R1 reset addr", int'(fetch_addr), 0);
        check("R1 reset ovf", int'(ovf_flag), 0);
        check("R1 reset unf", int'(unf_flag), 0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][31:26], VEC[i][25:13]);
            check($sformatf("vector %0d", i), int'(fetch_addr), int'(VEC[i][12:0]));
        end
        check("R7 no ovf after table", int'(ovf_flag), 0);
        check("R8 no unf after table", int'(unf_flag), 0);

        // R8: return on an empty stack right after reset
        do_reset();
        apply(6'b100000, '0);
        check("R8 empty return addr", int'(fetch_addr), 0);
        check("R8 unf set", int'(unf_flag), 1);
        check("R8 ovf clear", int'(ovf_flag), 0);
        apply(6'b000001, '0);
        check("R8 unf sticky", int'(unf_flag), 1);

        // R7: nine nested calls; call k saves 16*k+1 (first saves 1)
        do_reset();
        for (int k = 0; k < 9; k++) begin
            apply(6'b010000, AW'(16 * (k + 1)));
            check($sformatf("R6 call %0d target", k), int'(fetch_addr), 16 * (k + 1));
            check($sformatf("R7 ovf after call %0d", k), int'(ovf_flag), (k == 8) ? 1 : 0);
        end
        for (int k = 8; k >= 1; k--) begin
            apply(6'b100000, '0);
            check($sformatf("R7 unwind to call %0d", k), int'(fetch_addr), 16 * k + 1);
        end
        check("R7 ovf sticky", int'(ovf_flag), 1);
        check("R8 unf clear after 8 returns", int'(unf_flag), 0);
        apply(6'b100000, '0);
        check("R8 wrapped entry", int'(fetch_addr), 16 * 8 + 1);
        check("R8 unf on ninth return", int'(unf_flag), 1);

        // R1: reset clears the sticky flags
        do_reset();
        check("R1 flags cleared ovf", int'(ovf_flag), 0);
        check("R1 flags cleared unf", int'(unf_flag), 0);
        check("R1 addr cleared", int'(fetch_addr), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule